// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x oversampling tick for a serial line from a source clock. Software loads an integer divisor and a fraction counted in sixteenths. A tick period normally lasts divisor+1 source cycles. Within every run of 16 ticks, a number of periods equal to the fraction get one extra cycle, so the mean divisor is divisor+1+fraction/16. For example, a 100 MHz source and 115200 baud give a divisor of 53 and a fraction of 4, which is an effective value of 54.25 source cycles per tick. A bit strobe comes with every sixteenth tick, which gives the line bit rate.

A three-state controller runs the timing. OFF is the idle state, entered while `enable` is low. BASE counts the divisor+1 cycles of a period. EXTRA is the single stretch cycle. The transitions are:
- OFF to BASE when enabled.
- BASE to BASE at a plain period end.
- BASE to EXTRA when the fraction accumulator carries.
- EXTRA to BASE after the stretch cycle.
- Any state to OFF when `enable` drops.
- Any state to BASE with all counters cleared when the divisor or fraction value changes while enabled.

A 4-bit accumulator adds the fraction once per period. A period is stretched when that addition carries, which spreads the stretched periods evenly across each run of 16.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is asserted, and after reset with `enable` low, `tick` and `bit_stb` are 0.
- R2: With fraction 0, ticks are spaced exactly divisor+1 cycles apart.
- R3: With fraction f, the spacing between two successive bit strobes is exactly 16*(divisor+1)+f cycles.
- R4: `bit_stb` is high only together with `tick`. After a restart it marks ticks number 16, 32, 48 and so on.
- R5: Number the periods k = 1, 2, ... from a restart. Period k lasts divisor+2 cycles when ((k-1)*f mod 16) + f >= 16, and divisor+1 cycles otherwise.
- R6: After the first clock edge that samples `enable` low, both outputs stay 0. When `enable` returns, timing restarts from period 1 and group position 0.
- R7: Call a restart edge the first edge that samples `enable` high after it was low, or the first edge that samples a changed divisor or fraction. The first tick is visible after the edge divisor+1 edges later. Period numbering restarts at 1.
- R8: A divisor of 0 gives a tick on every cycle with fraction 0. With fraction 15 it gives periods of 1 or 2 cycles.
- R9: With divisor 53 and fraction 4, bit strobes are 868 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds the block idle with outputs low |
| divisor | input | DIV_W | Integer divisor; base period is divisor+1 cycles |
| fraction | input | FRAC_W | Fraction in sixteenths; number of stretched periods per 16 |
| tick | output | 1 | One-cycle oversample tick at the end of each period |
| bit_stb | output | 1 | One-cycle strobe on every sixteenth tick |

## Verification
The bench builds the block with DIV_W = 8 and FRAC_W = 4. That keeps the runs short and still covers the divisor of 53 from the worked example and the boundary divisor of 0. With the 4-bit fraction, every code can be reached, including the edge codes 0, 1 and 15, where the stretch pattern is empty, sparsest or nearly full. The bench predicts the arrival cycle of every tick from the spreading rule, so any misplaced stretch or off-by-one period is caught on the exact tick where it happens.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
    typedef enum logic [1:0] {
        BG_OFF   = 2'd0,
        BG_BASE  = 2'd1,
        BG_EXTRA = 2'd2
    } bg_state_e;
endpackage

// File: rtl/baud_cfg_watch.sv
// Holds registered copies of the divisor and fraction and flags any change.
module baud_cfg_watch #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              changed
);
    always_comb changed = (div_in != div_q) || (frac_in != frac_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            frac_q <= '0;
        end else begin
            div_q  <= div_in;
            frac_q <= frac_in;
        end
    end
endmodule

// File: rtl/baud_frac_acc.sv
// Fraction accumulator: a carry on the running sum marks the current period as stretched.
module baud_frac_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (step)  acc <= sum[FRAC_W-1:0];
    end

    // R2: a zero fraction never stretches a period
    assert_no_carry_zero_frac_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frac == '0) |-> !carry);
endmodule

// File: rtl/baud_grp_cnt.sv
// Counts ticks within a group; flags the last tick of each group.
module baud_grp_cnt #(
    parameter int FRAC_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [FRAC_W-1:0] grp;

    always_comb last = &grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     grp <= '0;
        else if (clear) grp <= '0;
        else if (step)  grp <= grp + FRAC_W'(1);
    end

    assert_group_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !clear) |=> (grp == '0));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [FRAC_W-1:0] fraction,
    output logic              tick,
    output logic              bit_stb
);
    import baud_frac_pkg::*;

    bg_state_e         st, st_nx;
    logic [DIV_W-1:0]  cnt, cnt_nx;
    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    logic              changed, carry, last;
    logic              clear, period_end;
    logic              tick_q, stb_q;

    baud_cfg_watch #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .div_in(divisor), .frac_in(fraction),
        .div_q(div_q), .frac_q(frac_q), .changed(changed)
    );

    baud_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(period_end),
        .frac(frac_q), .carry(carry)
    );

    baud_grp_cnt #(.FRAC_W(FRAC_W)) u_grp (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(period_end),
        .last(last)
    );

    always_comb clear = !enable || changed;

    // next-state process
    always_comb begin
        st_nx      = st;
        cnt_nx     = cnt;
        period_end = 1'b0;
        unique case (st)
            BG_OFF: begin
                st_nx  = BG_BASE;
                cnt_nx = '0;
            end
            BG_BASE: begin
                if (cnt == div_q) begin
                    cnt_nx = '0;
                    if (carry) st_nx = BG_EXTRA;
                    else       period_end = 1'b1;
                end else begin
                    cnt_nx = cnt + DIV_W'(1);
                end
            end
            BG_EXTRA: begin
                st_nx      = BG_BASE;
                cnt_nx     = '0;
                period_end = 1'b1;
            end
            default: begin
                st_nx  = BG_OFF;
                cnt_nx = '0;
            end
        endcase
        if (clear) begin
            st_nx      = enable ? BG_BASE : BG_OFF;
            cnt_nx     = '0;
            period_end = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= BG_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            tick_q <= period_end;
            stb_q  <= period_end && last;
        end
    end

    assign tick    = tick_q;
    assign bit_stb = stb_q;

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tick && !bit_stb));

    assert_stb_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> tick);

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && changed) |=> (st == BG_BASE && cnt == '0 && !tick));

    assert_extra_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BG_EXTRA && !clear) |=> (tick && st == BG_BASE));

    assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q != '0) |=> !tick);
endmodule

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
    localparam int DW  = 8;
    localparam int FW  = 4;
    localparam int GRP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic [FW-1:0] fraction = '0;
    logic          tick, bit_stb;

    int n_chk = 0;
    int n_bad = 0;

    baud_frac_gen #(.DIV_W(DW), .FRAC_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
        .fraction(fraction), .tick(tick), .bit_stb(bit_stb)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (4) begin
            @(negedge clk);
            check(!tick && !bit_stb, "R1", int'(tick) + int'(bit_stb), 0, "outputs in reset");
        end
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(!tick && !bit_stb, "R1", int'(tick) + int'(bit_stb), 0, "outputs idle after reset");
        end
    endtask

    // Restart, then verify the arrival cycle of every tick and the strobe pattern.
    task automatic run_pattern(input int d, input int f, input int nticks, input bit via_enable, input string req);
        int e = 0;
        int expect_at = 1;
        int acc = 0;
        int strobe_prev = -1;
        if (via_enable) begin
            @(negedge clk) enable = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        divisor  = DW'(d);
        fraction = FW'(f);
        enable   = 1'b1;
        for (int k = 1; k <= nticks; k++) begin
            int len;
            bit seen;
            len  = d + 1 + (((acc + f) >= GRP) ? 1 : 0);
            acc  = (acc + f) % GRP;
            expect_at += len;
            seen = 1'b0;
            while (!seen && e < expect_at + 4) begin
                @(negedge clk);
                e++;
                if (tick) seen = 1'b1;
                else if (bit_stb) check(1'b0, "R4", 1, 0, "strobe without tick");
            end
            check(seen && e == expect_at, req, seen ? e : -1, expect_at,
                  $sformatf("tick %0d arrival (d=%0d f=%0d)", k, d, f));
            check(bit_stb == (k % GRP == 0), "R4", int'(bit_stb), int'(k % GRP == 0),
                  $sformatf("strobe flag on tick %0d", k));
            if (bit_stb) begin
                if (strobe_prev >= 0)
                    check(e - strobe_prev == GRP * (d + 1) + f, req, e - strobe_prev,
                          GRP * (d + 1) + f, "strobe spacing");
                strobe_prev = e;
            end
            if (!seen) break;
        end
    endtask

    task automatic t_disable();
        run_pattern(4, 3, 20, 1'b1, "R5");
        @(negedge clk) enable = 1'b0;
        repeat (30) begin
            @(negedge clk);
            check(!tick && !bit_stb, "R6", int'(tick) + int'(bit_stb), 0, "outputs while disabled");
        end
        run_pattern(4, 3, 18, 1'b1, "R6");
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        run_pattern(5, 0, 20, 1'b1, "R2");
        run_pattern(5, 4, 33, 1'b1, "R3");
        run_pattern(2, 1, 33, 1'b1, "R5");
        run_pattern(3, 15, 33, 1'b1, "R5");
        run_pattern(7, 8, 33, 1'b1, "R3");
        t_disable();
        run_pattern(6, 2, 10, 1'b1, "R7");
        run_pattern(3, 2, 20, 1'b0, "R7");
        run_pattern(3, 9, 33, 1'b0, "R7");
        run_pattern(0, 0, 20, 1'b1, "R8");
        run_pattern(0, 15, 33, 1'b1, "R8");
        run_pattern(53, 4, 33, 1'b1, "R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule